// File: doc/BRIEF.md
# Fractional-Rate Free-Running Counter

This block keeps a wide time count that runs at a fixed nominal rate, such as 6.144 MHz, while being clocked by a faster system clock. Each system clock adds a programmable numerator to a fractional accumulator. When the accumulator reaches the programmed denominator, the denominator is taken away and the count steps by one. Over time the count therefore advances at the clock rate times num/den.

Software picks the ratio that fits the system clock through two 32-bit registers. Only the low 12 bits of each register form the ratio. The upper 20 bits are plain storage that reads back unchanged, so firmware can update the ratio with read-modify-write. A slower coarse reference tick can also realign the fine count. On each tick the count is loaded with the running coarse position: the number of ticks seen so far times a parameterized number of counts per tick. With the default of 375, this corresponds to a 16.384 kHz tick. Local timers read the count directly.

Top module: `frac_rate_counter`

## Requirements
- R1: After reset the count is zero. The numerator register reads 0x00000004 and the denominator register reads 0x00000019 (a ratio of 4/25).
- R2: With the ratio fields num < den and no register write or coarse tick, every den consecutive clocks advance the count by exactly num. This holds for 64/125, 768/1625, 8/25, 192/625, 384/1625, 256/1125, 4/25 and 75/244.
- R3: Outside a coarse tick, the count changes by at most +1 per clock.
- R4: The numerator register is at byte address 0x10 and the denominator register is at 0x14. Both read back all 32 written bits. Any other address reads zero, and writes to it change no register.
- R5: Only bits [11:0] of each register form the ratio. Bits [31:12] are stored and read back, but they have no effect on the count rate.
- R6: A write to either ratio register clears the accumulator. The count does not step on the write clock, and the new ratio starts from zero phase.
- R7: A one-clock pulse on coarse_tick loads the count with k*375 on the next edge, where k is the number of ticks since reset including this one. It also clears the accumulator.
- R8: When a coarse tick and a ratio write fall in the same clock, the count takes the coarse value and the register write still takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| coarse_tick | input | 1 | One-clock coarse reference pulse |
| count | output | 64 | Free-running time count |

## Verification
The accumulator-bound property assumes that software keeps the numerator field below a nonzero denominator field. The step and coarse-alignment properties assume that coarse_tick is a single-clock pulse. The property also assumes that the count never wraps the coarse grid within a run.

Every ratio the bench programs satisfies num < den. It always writes the numerator before the denominator, back to back, so no stepping clock ever sees an illegal pair. Ticks are driven for exactly one clock, and runs are far too short to approach a 64-bit wrap.

// File: rtl/frac_rate_counter.sv
module frac_rate_counter #(
  parameter int CNT_W     = 64,
  parameter int RATIO_W   = 12,
  parameter int ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] NUM_ADDR = 8'h10,
  parameter logic [ADDR_W-1:0] DEN_ADDR = 8'h14,
  parameter int RST_NUM   = 4,
  parameter int RST_DEN   = 25,
  parameter int TICK_STEP = 375
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              coarse_tick,
  output logic [CNT_W-1:0]  count
);

  localparam logic [CNT_W-1:0] STEP = CNT_W'(TICK_STEP);

  logic [31:0]        num_r, den_r;
  logic [RATIO_W-1:0] acc;
  logic [CNT_W-1:0]   coarse_base;

  wire [RATIO_W-1:0] num_f = num_r[RATIO_W-1:0];
  wire [RATIO_W-1:0] den_f = den_r[RATIO_W-1:0];
  wire               wr_num = reg_wr && reg_addr == NUM_ADDR;
  wire               wr_den = reg_wr && reg_addr == DEN_ADDR;
  wire               ratio_wr = wr_num || wr_den;
  wire [RATIO_W:0]   sum = {1'b0, acc} + {1'b0, num_f};
  wire               hit = sum >= {1'b0, den_f};
  wire [RATIO_W:0]   wrapped = sum - {1'b0, den_f};
  wire [RATIO_W-1:0] acc_next = hit ? wrapped[RATIO_W-1:0] : sum[RATIO_W-1:0];
  wire [CNT_W-1:0]   coarse_next = coarse_base + STEP;

  assign reg_rdata = (reg_addr == NUM_ADDR) ? num_r :
                     (reg_addr == DEN_ADDR) ? den_r : 32'h0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      num_r <= 32'(RST_NUM);
      den_r <= 32'(RST_DEN);
    end else begin
      if (wr_num) num_r <= reg_wdata;
      if (wr_den) den_r <= reg_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc         <= '0;
      count       <= '0;
      coarse_base <= '0;
    end else if (coarse_tick) begin
      acc         <= '0;
      coarse_base <= coarse_next;
      count       <= coarse_next;
    end else if (ratio_wr) begin
      acc <= '0;
    end else begin
      acc <= acc_next;
      if (hit) count <= count + 1'b1;
    end
  end

endmodule

module frac_rate_counter_chk #(
  parameter int CNT_W     = 64,
  parameter int RATIO_W   = 12,
  parameter int ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] NUM_ADDR = 8'h10,
  parameter logic [ADDR_W-1:0] DEN_ADDR = 8'h14,
  parameter int TICK_STEP = 375
) (
  input logic               clk,
  input logic               rst_n,
  input logic               reg_wr,
  input logic [ADDR_W-1:0]  reg_addr,
  input logic               coarse_tick,
  input logic [CNT_W-1:0]   count,
  input logic [RATIO_W-1:0] acc,
  input logic [RATIO_W-1:0] num_f,
  input logic [RATIO_W-1:0] den_f
);

  wire ratio_wr = reg_wr && (reg_addr == NUM_ADDR || reg_addr == DEN_ADDR);

  assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !coarse_tick |=> (count == $past(count) || count == $past(count) + 1'b1));

  assert_acc_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc < den_f && num_f < den_f && !ratio_wr) |=> acc < den_f);

  assert_wr_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ratio_wr |=> acc == '0);

  assert_coarse_align_R7: assert property (@(posedge clk) disable iff (!rst_n)
    coarse_tick |=> (acc == '0 && count % CNT_W'(TICK_STEP) == '0));

endmodule

bind frac_rate_counter frac_rate_counter_chk #(
  .CNT_W(CNT_W), .RATIO_W(RATIO_W), .ADDR_W(ADDR_W),
  .NUM_ADDR(NUM_ADDR), .DEN_ADDR(DEN_ADDR), .TICK_STEP(TICK_STEP)
) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .coarse_tick(coarse_tick), .count(count), .acc(acc),
  .num_f(num_f), .den_f(den_f)
);

// File: tb/frac_rate_counter_bench.sv
module frac_rate_counter_bench;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        reg_wr = 0;
  logic [7:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata;
  logic        coarse_tick = 0;
  logic [63:0] count;

  int checks = 0, errors = 0, ticks = 0;
  bit done = 0;

  frac_rate_counter u_frac_rate_counter (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .coarse_tick(coarse_tick), .count(count)
  );

  always #10 clk = ~clk;

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    check("R1 count", count, 0);
    rd(8'h10, d); check("R1 num", {32'h0, d}, 64'h4);
    rd(8'h14, d); check("R1 den", {32'h0, d}, 64'h19);
  endtask

  task automatic t_ratio(int n, int d);
    logic [63:0] c0;
    wr(8'h10, 32'(n));
    wr(8'h14, 32'(d));
    c0 = count;
    repeat (d) @(posedge clk);
    @(negedge clk);
    check($sformatf("R2 ratio %0d/%0d", n, d), count - c0, 64'(n));
  endtask

  task automatic t_upper_bits;
    logic [31:0] d;
    logic [63:0] c0;
    wr(8'h10, 32'hABCDE040);
    wr(8'h14, 32'h1230007D);
    c0 = count;
    rd(8'h10, d); check("R5 num readback", {32'h0, d}, 64'hABCDE040);
    rd(8'h14, d); check("R5 den readback", {32'h0, d}, 64'h1230007D);
    repeat (125) @(posedge clk);
    @(negedge clk);
    check("R5 rate with upper bits", count - c0, 64);
  endtask

  task automatic t_bad_addr;
    logic [31:0] d;
    wr(8'h18, 32'hFFFFFFFF);
    wr(8'h00, 32'hFFFFFFFF);
    rd(8'h18, d); check("R4 unmapped read", {32'h0, d}, 0);
    rd(8'h10, d); check("R4 num untouched", {32'h0, d}, 64'hABCDE040);
    rd(8'h14, d); check("R4 den untouched", {32'h0, d}, 64'h1230007D);
  endtask

  task automatic t_wr_clear;
    logic [63:0] c0;
    wr(8'h10, 32'd8);
    wr(8'h14, 32'd25);
    repeat (20) @(negedge clk);
    wr(8'h14, 32'd25);
    c0 = count;
    repeat (3) @(negedge clk);
    check("R6 clean phase hold", count, c0);
    @(negedge clk);
    check("R6 clean phase step", count, c0 + 1);
  endtask

  task automatic t_coarse;
    for (int i = 0; i < 2; i++) begin
      coarse_tick = 1;
      @(negedge clk);
      coarse_tick = 0;
      ticks++;
      check("R7 coarse load", count, 64'(ticks * 375));
    end
    repeat (3) @(negedge clk);
    check("R7 acc cleared hold", count, 64'(ticks * 375));
    @(negedge clk);
    check("R7 acc cleared step", count, 64'(ticks * 375 + 1));
  endtask

  task automatic t_collide;
    logic [31:0] d;
    reg_addr = 8'h10; reg_wdata = 32'd64; reg_wr = 1; coarse_tick = 1;
    @(negedge clk);
    reg_wr = 0; coarse_tick = 0;
    ticks++;
    check("R8 coarse wins", count, 64'(ticks * 375));
    rd(8'h10, d); check("R8 write kept", {32'h0, d}, 64);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_ratio(64, 125);
    t_ratio(768, 1625);
    t_ratio(8, 25);
    t_ratio(192, 625);
    t_ratio(384, 1625);
    t_ratio(256, 1125);
    t_ratio(4, 25);
    t_ratio(75, 244);
    t_upper_bits();
    t_bad_addr();
    t_wr_clear();
    t_coarse();
    t_collide();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (50000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=running expected=done");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule